// File: doc/BRIEF.md
# SDRAM Read Burst Precharge Scheduler

This block sequences commands for one bank of an SDRAM controller. It takes a read request for a row that is already open. It issues the READ, then places an explicit PRECHARGE at the earliest slot that still delivers every wanted data word. Once the row-precharge time has passed, it issues the ACTIVE that reopens a row. The precharge slot depends on the CAS latency and on the position of the last wanted word. The block can therefore cut a fixed-length or full-page burst short, and it hides part of the precharge time behind the final reads.

Each request carries:
- a bank and a column;
- the row to open afterwards;
- a CAS-latency select;
- the number of wanted words;
- an auto-precharge flag;
- the precharge time in cycles.

The block drops `ready` while it works and raises it again after the ACTIVE has gone out.

Top module: `rdpre_sched`

## Requirements
- R1: After reset, `cmd` is NOP, `ready` is high, and `rd_valid` and `dqm` are low.
- R2: A request that is present at a clock edge while `ready` is high produces a READ in the next cycle. On `cmd`, 2'b00 means NOP, 2'b01 means READ, 2'b10 means PRECHARGE and 2'b11 means ACTIVE. On the READ, `cmd_bank` carries the request bank. `cmd_addr[COL_W-1:0]` carries the column, and `cmd_addr[10]` carries the auto-precharge flag.
- R3: Without auto precharge, one PRECHARGE to the request bank, with `cmd_addr[10]` low, goes out exactly `req_len` cycles after the READ. That slot is CL-1 cycles before the last wanted word is valid. A length of 0 counts as 1, and lengths up to 256 are accepted for full-page bursts.
- R4: `rd_valid` is high from CL cycles after the READ for exactly `req_len` consecutive cycles. CL is 2 when `req_cl3` is low and 3 when it is high.
- R5: With auto precharge, no PRECHARGE is issued. The precharge timer starts at the slot where the PRECHARGE would have gone, so the ACTIVE comes in the same cycle as for the same burst with an explicit PRECHARGE.
- R6: The ACTIVE, carrying the request row on `cmd_addr` and the request bank, goes out exactly `req_trp` cycles after the precharge slot. A value of 0 counts as 1.
- R7: Every cycle of a request other than its READ, PRECHARGE and ACTIVE carries NOP, and `dqm` stays low throughout.
- R8: `ready` is low from the cycle after acceptance until the cycle after the ACTIVE, when it returns high. Requests presented while it is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Row opened by the closing ACTIVE |
| req_col | input | COL_W | Start column of the read |
| req_cl3 | input | 1 | CAS latency 3 when high, 2 when low |
| req_len | input | LEN_W | Wanted data words (0 counts as 1) |
| req_ap | input | 1 | Read with auto precharge |
| req_trp | input | TRP_W | Row-precharge time in cycles (0 counts as 1) |
| cmd | output | 2 | Command: NOP, READ, PRECHARGE, ACTIVE |
| cmd_bank | output | BANK_W | Bank of the command |
| cmd_addr | output | ADDR_W | Address of the command |
| dqm | output | 1 | Data mask, held low |
| rd_valid | output | 1 | Read data word valid on this cycle |
| ready | output | 1 | Able to accept a request |

## Verification
A slot counter that is off by one moves the PRECHARGE, and the ACTIVE moves with it. Both shifts show on `cmd` within the same request, before `ready` returns. If the PRECHARGE comes early, the wanted data is truncated. If it comes late, the precharge time is lost. A data counter that starts or stops wrong moves the first or last `rd_valid` pulse, or changes the pulse count, within a few cycles of the READ. A state machine that leaves its idle state wrongly shows as a second READ, or as a `ready` that rises without a preceding ACTIVE.

// File: rtl/rdpre_sched.sv
module rdpre_sched #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 9,
  parameter int ADDR_W = 12,
  parameter int AP_BIT = 10,
  parameter int LEN_W  = 9,
  parameter int TRP_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_cl3,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_ap,
  input  logic [TRP_W-1:0]  req_trp,
  output logic [1:0]        cmd,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              dqm,
  output logic              rd_valid,
  output logic              ready
);
  localparam logic [1:0] C_NOP = 2'b00;
  localparam logic [1:0] C_RD  = 2'b01;
  localparam logic [1:0] C_PRE = 2'b10;
  localparam logic [1:0] C_ACT = 2'b11;
  localparam int DW = LEN_W + 1;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_TRP, S_ACT} st_t;
  st_t st;

  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  row_q;
  logic [LEN_W-1:0]  len_q, cnt;
  logic [TRP_W-1:0]  trp_q, tcnt;
  logic              ap_q;
  logic              dact;
  logic [DW-1:0]     dcnt, dbeg, dend;

  logic [LEN_W-1:0]  len_in;
  logic [TRP_W-1:0]  trp_in;
  logic [1:0]        cl_in;
  logic [ADDR_W-1:0] rd_addr;
  logic [LEN_W-1:0]  cnt_nx;
  logic [TRP_W-1:0]  tcnt_nx;
  logic [DW-1:0]     dcnt_nx;
  logic              take;

  assign len_in  = (req_len == '0) ? LEN_W'(1) : req_len;
  assign trp_in  = (req_trp == '0) ? TRP_W'(1) : req_trp;
  assign cl_in   = req_cl3 ? 2'd3 : 2'd2;
  assign cnt_nx  = cnt + LEN_W'(1);
  assign tcnt_nx = tcnt + TRP_W'(1);
  assign dcnt_nx = dcnt + DW'(1);
  assign take    = (st == S_IDLE) && req_valid;
  assign dqm     = 1'b0;

  always_comb begin
    rd_addr = '0;
    rd_addr[COL_W-1:0] = req_col;
    rd_addr[AP_BIT] = req_ap;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cmd <= C_NOP;
      cmd_bank <= '0;
      cmd_addr <= '0;
      ready <= 1'b1;
      bank_q <= '0;
      row_q <= '0;
      len_q <= '0;
      trp_q <= '0;
      ap_q <= 1'b0;
      cnt <= '0;
      tcnt <= '0;
    end else begin
      cmd <= C_NOP;
      case (st)
        S_IDLE: if (take) begin
          bank_q <= req_bank;
          row_q <= req_row;
          len_q <= len_in;
          trp_q <= trp_in;
          ap_q <= req_ap;
          cmd <= C_RD;
          cmd_bank <= req_bank;
          cmd_addr <= rd_addr;
          ready <= 1'b0;
          cnt <= '0;
          st <= S_RUN;
        end
        S_RUN: begin
          cnt <= cnt_nx;
          if (cnt_nx == len_q) begin
            if (!ap_q) begin
              cmd <= C_PRE;
              cmd_bank <= bank_q;
              cmd_addr <= '0;
            end
            tcnt <= '0;
            st <= S_TRP;
          end
        end
        S_TRP: begin
          tcnt <= tcnt_nx;
          if (tcnt_nx == trp_q) begin
            cmd <= C_ACT;
            cmd_bank <= bank_q;
            cmd_addr <= ADDR_W'(row_q);
            st <= S_ACT;
          end
        end
        S_ACT: begin
          ready <= 1'b1;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dact <= 1'b0;
      dcnt <= '0;
      dbeg <= '0;
      dend <= '0;
      rd_valid <= 1'b0;
    end else if (take) begin
      dact <= 1'b1;
      dcnt <= '0;
      dbeg <= DW'(cl_in);
      dend <= DW'(cl_in) + DW'(len_in) - DW'(1);
      rd_valid <= 1'b0;
    end else if (dact) begin
      dcnt <= dcnt_nx;
      rd_valid <= (dcnt_nx >= dbeg) && (dcnt_nx <= dend);
      if (dcnt_nx >= dend) dact <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
    end
  end
endmodule

module rdpre_sched_chk #(
  parameter int BANK_W = 2,
  parameter int ADDR_W = 12,
  parameter int AP_BIT = 10,
  parameter int TRP_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [TRP_W-1:0]  req_trp,
  input logic [1:0]        cmd,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              rd_valid,
  input logic              ready
);
  logic             ap_f;
  logic [TRP_W:0]   since_pre;
  logic [TRP_W:0]   trp_lat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ap_f <= 1'b0;
      since_pre <= '0;
      trp_lat <= '0;
    end else begin
      if (cmd == 2'b01) ap_f <= cmd_addr[AP_BIT];
      else if (cmd == 2'b11) ap_f <= 1'b0;
      if (cmd == 2'b10) since_pre <= (TRP_W+1)'(1);
      else if (since_pre != '1) since_pre <= since_pre + (TRP_W+1)'(1);
      if (req_valid && ready)
        trp_lat <= (req_trp == '0) ? (TRP_W+1)'(1) : (TRP_W+1)'(req_trp);
    end
  end

  // R2
  read_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 2'b01) |-> $past(ready));
  // R8
  busy_during_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 2'b01) |-> !ready);
  // R8
  ready_after_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 2'b11) |=> ready);
  // R8
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> ($past(cmd) == 2'b11));
  // R5
  no_pre_with_ap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ap_f && cmd == 2'b10));
  // R6
  trp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 2'b11 && !ap_f) |-> (since_pre == trp_lat));
  // R4
  no_data_at_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 2'b01) |-> !rd_valid);
endmodule

bind rdpre_sched rdpre_sched_chk #(
  .BANK_W(BANK_W), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT), .TRP_W(TRP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_trp(req_trp),
  .cmd(cmd), .cmd_addr(cmd_addr), .rd_valid(rd_valid), .ready(ready)
);

// File: tb/rdpre_sched_tb.sv
`timescale 1ns/1ps
module rdpre_sched_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_bank = '0;
  logic [11:0] req_row = '0;
  logic [8:0] req_col = '0;
  logic req_cl3 = 1'b0;
  logic [8:0] req_len = '0;
  logic req_ap = 1'b0;
  logic [3:0] req_trp = '0;
  logic [1:0] cmd;
  logic [1:0] cmd_bank;
  logic [11:0] cmd_addr;
  logic dqm, rd_valid, ready;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rdpre_sched u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bank(req_bank),
    .req_row(req_row), .req_col(req_col), .req_cl3(req_cl3), .req_len(req_len),
    .req_ap(req_ap), .req_trp(req_trp), .cmd(cmd), .cmd_bank(cmd_bank),
    .cmd_addr(cmd_addr), .dqm(dqm), .rd_valid(rd_valid), .ready(ready)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_case(input bit cl3, input int len, input int trp,
                          input bit ap, input bit poke);
    int le = (len == 0) ? 1 : len;
    int te = (trp == 0) ? 1 : trp;
    int cl = cl3 ? 3 : 2;
    int pre = -1, act = -1, fv = -1, lv = -1, nv = 0, reads = 0, rdy = -1;
    int nonop = 0, dq = 0, rd_a = -1, rd_b = -1, pre_a = -1, pre_b = -1;
    int act_a = -1, act_b = -1;
    int exp_rd = 'h0C3 | (ap ? (1 << 10) : 0);
    while (!ready) @(negedge clk);
    req_bank = 2'd1; req_row = 12'h5A5; req_col = 9'h0C3;
    req_cl3 = cl3; req_len = 9'(len); req_ap = ap; req_trp = 4'(trp);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int c = 0; c < 600; c++) begin
      if (cmd != 2'b00) nonop++;
      if (cmd == 2'b01) begin reads++; if (c == 0) begin rd_a = cmd_addr; rd_b = cmd_bank; end end
      if (cmd == 2'b10 && pre < 0) begin pre = c; pre_a = cmd_addr; pre_b = cmd_bank; end
      if (cmd == 2'b11 && act < 0) begin act = c; act_a = cmd_addr; act_b = cmd_bank; end
      if (rd_valid) begin if (fv < 0) fv = c; lv = c; nv++; end
      if (dqm) dq++;
      if (ready && c > 0) begin rdy = c; break; end
      if (poke && c == 2) begin req_valid = 1'b1; req_col = 9'h011; end
      if (poke && c == 3) req_valid = 1'b0;
      @(negedge clk);
    end
    chk("R2 read count", reads, 1);
    chk("R2 read addr", rd_a, exp_rd);
    chk("R2 read bank", rd_b, 1);
    if (ap) chk("R5 no precharge", pre, -1);
    else begin
      chk("R3 precharge slot", pre, le);
      chk("R3 precharge addr", pre_a, 0);
      chk("R3 precharge bank", pre_b, 1);
    end
    chk("R6 active slot", act, le + te);
    chk("R6 active row", act_a, 'h5A5);
    chk("R6 active bank", act_b, 1);
    chk("R4 first valid", fv, cl);
    chk("R4 last valid", lv, cl + le - 1);
    chk("R4 valid count", nv, le);
    chk("R7 non-NOP cycles", nonop, ap ? 2 : 3);
    chk("R7 dqm low", dq, 0);
    chk("R8 ready return", rdy, le + te + 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 cmd nop", cmd, 0);
    chk("R1 ready", ready, 1);
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 dqm", dqm, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      for (int t = 2; t <= 3; t++) begin
        run_case(k[0], 1, t, 1'b0, 1'b0);
        run_case(k[0], 2, t, 1'b0, 1'b0);
        run_case(k[0], 4, t, 1'b0, 1'b0);
        run_case(k[0], 8, t, 1'b0, 1'b0);
      end
    end
    run_case(1'b0, 4, 3, 1'b1, 1'b0);
    run_case(1'b1, 4, 2, 1'b1, 1'b0);
    run_case(1'b1, 256, 2, 1'b0, 1'b0);
    run_case(1'b0, 0, 2, 1'b0, 1'b0);
    run_case(1'b1, 3, 0, 1'b0, 1'b0);
    run_case(1'b1, 6, 3, 1'b0, 1'b1);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule